// File: doc/BRIEF.md
# Quad DAC Serial Control Interface

This block is the digital front end of a four-channel converter. A host writes 32-bit frames over a three-wire serial link: a serial clock, a data line and an active-low frame select. Data is taken on the falling serial clock edge, most significant bit first. When the frame select rises after at least 32 falling edges, the last 32 bits form a command. A 4-bit operation field selects one of four actions: write a channel code, set the power-down mode of a group of channels, run a software reset, or write the setup register. The setup register holds the chain-forwarding enable and the internal-reference enable.

The serial pins are asynchronous to the system clock. They are resynchronised through a chain of flops whose length is set by a parameter, and edges are detected in the system clock domain. The outputs are all registered: four 16-bit channel codes, four 2-bit power-down modes and a reference-enable flag. A power-on select input picks zero scale or midscale as the code that reset restores. When chain forwarding is on, bits older than 32 falling edges leave on the serial output. That output changes after each rising serial clock edge, so a downstream device can take it on the next falling edge.

Top module: `qdac_serial_ctrl`

## Requirements
- R1: A frame is accepted only when at least 32 falling serial clock edges arrive while the frame select is low. If the select rises earlier, the frame is discarded and no output changes.
- R2: Bits enter most significant first. In the accepted 32-bit word, bits 27:24 are the operation, bits 23:20 the address and bits 19:4 the 16-bit code. Bits 31:28 are ignored.
- R3: Operations 0000, 0001, 0010 and 0011 write the code into the channel given by the address (0 to 3 for channels A to D), or into all four channels when the address is 1111.
- R4: Synchronous reset sets every code to 0x0000 when the power-on select is low and to 0x8000 when it is high. Reset also clears all power-down modes, the reference enable and chain forwarding.
- R5: Operation 0111 returns every channel code to the power-on code given by the current power-on select. Power-down modes and setup bits are not changed.
- R6: Operation 1000 loads the setup register: word bit 1 sets chain forwarding and word bit 0 sets the reference enable.
- R7: Operation 0100 writes the mode in word bits 19:18 (00 means normal) to each channel whose select bit is set. The select bits are bit 0 for A, bit 1 for B, bit 6 for C and bit 7 for D. Unselected channels and all channel codes keep their values.
- R8: While the reference enable is set, operation 0100 applies its mode to all four channels whatever the select bits hold.
- R9: While chain forwarding is off, the serial output stays low. A frame longer than 32 clocks is decoded from its last 32 bits.
- R10: While chain forwarding is on, the serial output changes after each rising serial clock edge to the bit taken 32 falling edges earlier, and is low for the first 32 clocks of a frame.
- R11: Operations 0101, 0110 and 1001 to 1111, and write addresses 0100 to 1110, change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| por_mid_i | input | 1 | Power-on code select: 0 zero scale, 1 midscale |
| sclk_i | input | 1 | Serial clock, idles high |
| sync_n_i | input | 1 | Active-low frame select |
| din_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Chain-forwarding serial data out |
| code_o | output | 64 | Channel codes, channel A in bits 15:0 |
| pd_mode_o | output | 8 | Power-down modes, channel A in bits 1:0 |
| ref_en_o | output | 1 | Internal reference enable |

## Verification
The bench builds the block with three synchroniser stages instead of the default two. This stretches both the frame-commit latency and the rising-edge-to-output latency by one system cycle, which shows that the reference model's timing follows the parameter and is not fixed. The bench serial clock half-period is derived from that stage count. The bench drives short frames, exact frames, over-length frames in both forwarding modes, and power-down selections with the reference on and off.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int FRAME_W = 32;
  localparam int NUM_CH  = 4;
  localparam int CODE_W  = 16;
  localparam int PD_W    = 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int ADDR_W  = 4;

  localparam logic [3:0] OP_PWR   = 4'b0100;
  localparam logic [3:0] OP_SWRST = 4'b0111;
  localparam logic [3:0] OP_SETUP = 4'b1000;
  localparam logic [ADDR_W-1:0] ADDR_ALL = 4'hF;

  // Scattered per-channel select bits of the power-down word: D,C,B,A
  function automatic logic [NUM_CH-1:0] pd_select(input logic [FRAME_W-1:0] w);
    return {w[7], w[6], w[1], w[0]};
  endfunction

  function automatic logic [CODE_W-1:0] por_code(input logic mid);
    return {mid, {(CODE_W-1){1'b0}}};
  endfunction
endpackage

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx
  import qdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_i,
  input  logic               sync_n_i,
  input  logic               din_i,
  input  logic               daisy_en_i,
  output logic               sdo_o,
  output logic               frame_ok_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic [SYNC_STAGES-1:0] sclk_s, sync_s, din_s;
  logic sclk_d, sync_d;
  logic sclk_q, sync_q, din_q;
  logic sclk_fall, sclk_rise, sync_fall, sync_rise;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_s <= '1;
      sync_s <= '1;
      din_s  <= '0;
      sclk_d <= 1'b1;
      sync_d <= 1'b1;
    end else begin
      sclk_s[0] <= sclk_i;
      sync_s[0] <= sync_n_i;
      din_s[0]  <= din_i;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sclk_s[i] <= sclk_s[i-1];
        sync_s[i] <= sync_s[i-1];
        din_s[i]  <= din_s[i-1];
      end
      sclk_d <= sclk_q;
      sync_d <= sync_q;
    end
  end

  assign sclk_q    = sclk_s[SYNC_STAGES-1];
  assign sync_q    = sync_s[SYNC_STAGES-1];
  assign din_q     = din_s[SYNC_STAGES-1];
  assign sclk_fall = sclk_d & ~sclk_q;
  assign sclk_rise = ~sclk_d & sclk_q;
  assign sync_fall = sync_d & ~sync_q;
  assign sync_rise = ~sync_d & sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg      <= '0;
      cnt        <= '0;
      sdo_o      <= 1'b0;
      frame_ok_o <= 1'b0;
      frame_o    <= '0;
    end else begin
      frame_ok_o <= 1'b0;
      if (sync_fall) begin
        shreg <= '0;
        cnt   <= '0;
      end else if (!sync_q && sclk_fall) begin
        shreg <= {shreg[FRAME_W-2:0], din_q};
        if (cnt != FULL) cnt <= cnt + 1'b1;
      end
      if (sync_q)         sdo_o <= 1'b0;
      else if (sclk_rise) sdo_o <= daisy_en_i & shreg[FRAME_W-1];
      if (sync_rise && cnt == FULL) begin
        frame_ok_o <= 1'b1;
        frame_o    <= shreg;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL); // R1
  AST_SHORT_DROP: assert property (@(posedge clk) disable iff (rst)
    (sync_rise && cnt != FULL) |=> !frame_ok_o); // R1
  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    sync_q |=> $stable(cnt)); // R2
endmodule

// File: rtl/qdac_chan.sv
module qdac_chan
  import qdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              por_mid_i,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic              swrst_i,
  input  logic              pd_wr_i,
  input  logic [PD_W-1:0]   pd_mode_i,
  output logic [CODE_W-1:0] code_o,
  output logic [PD_W-1:0]   pd_o
);
  always_ff @(posedge clk) begin
    if (rst || swrst_i) code_o <= por_code(por_mid_i);
    else if (wr_i)      code_o <= wr_code_i;
  end

  always_ff @(posedge clk) begin
    if (rst)          pd_o <= '0;
    else if (pd_wr_i) pd_o <= pd_mode_i;
  end

  AST_PD_KEEPS_CODE: assert property (@(posedge clk) disable iff (rst)
    (pd_wr_i && !wr_i && !swrst_i) |=> $stable(code_o)); // R7
  AST_SWRST_POR: assert property (@(posedge clk) disable iff (rst)
    swrst_i |=> (code_o == {$past(por_mid_i), {(CODE_W-1){1'b0}}})); // R5
endmodule

// File: rtl/qdac_serial_ctrl.sv
module qdac_serial_ctrl
  import qdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     por_mid_i,
  input  logic                     sclk_i,
  input  logic                     sync_n_i,
  input  logic                     din_i,
  output logic                     sdo_o,
  output logic [NUM_CH*CODE_W-1:0] code_o,
  output logic [NUM_CH*PD_W-1:0]   pd_mode_o,
  output logic                     ref_en_o
);
  logic               frame_ok;
  logic [FRAME_W-1:0] frame;
  logic               daisy_q, ref_q;
  logic [3:0]         op;
  logic [ADDR_W-1:0]  addr;
  logic               is_wr, is_pd, is_rst, is_setup;
  logic [NUM_CH-1:0]  pd_sel;

  qdac_frame_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .sclk_i     (sclk_i),
    .sync_n_i   (sync_n_i),
    .din_i      (din_i),
    .daisy_en_i (daisy_q),
    .sdo_o      (sdo_o),
    .frame_ok_o (frame_ok),
    .frame_o    (frame)
  );

  assign op       = frame[27:24];
  assign addr     = frame[23:20];
  assign is_wr    = frame_ok && (op[3:2] == 2'b00);
  assign is_pd    = frame_ok && (op == OP_PWR);
  assign is_rst   = frame_ok && (op == OP_SWRST);
  assign is_setup = frame_ok && (op == OP_SETUP);
  assign pd_sel   = pd_select(frame);

  always_ff @(posedge clk) begin
    if (rst) begin
      daisy_q <= 1'b0;
      ref_q   <= 1'b0;
    end else if (is_setup) begin
      daisy_q <= frame[1];
      ref_q   <= frame[0];
    end
  end
  assign ref_en_o = ref_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit_wr, hit_pd;
    assign hit_wr = is_wr && ((addr == ADDR_W'(g)) || (addr == ADDR_ALL));
    assign hit_pd = is_pd && (ref_q || pd_sel[g]);
    qdac_chan u_ch (
      .clk       (clk),
      .rst       (rst),
      .por_mid_i (por_mid_i),
      .wr_i      (hit_wr),
      .wr_code_i (frame[19:4]),
      .swrst_i   (is_rst),
      .pd_wr_i   (hit_pd),
      .pd_mode_i (frame[19:18]),
      .code_o    (code_o[g*CODE_W +: CODE_W]),
      .pd_o      (pd_mode_o[g*PD_W +: PD_W])
    );
  end

  AST_SDO_STANDALONE: assert property (@(posedge clk) disable iff (rst)
    !daisy_q |-> !sdo_o); // R9
  AST_REF_ALL_CH: assert property (@(posedge clk) disable iff (rst)
    (is_pd && ref_q) |=> (pd_mode_o == {NUM_CH{$past(frame[19:18])}})); // R8
  AST_UNUSED_OP: assert property (@(posedge clk) disable iff (rst)
    (frame_ok && (op == 4'b0101 || op == 4'b0110 || op[3:0] > 4'b1000))
      |=> ($stable(code_o) && $stable(pd_mode_o) && $stable(ref_en_o))); // R11
endmodule

// File: tb/qdac_serial_ctrl_tb.sv
module qdac_serial_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC_ST    = 3;
  localparam int HALF       = SYNC_ST + 2;

  logic clk = 1'b0, rst = 1'b1, por_mid = 1'b0;
  logic sclk = 1'b1, sync_n = 1'b1, din = 1'b0;
  logic sdo, ref_en;
  logic [63:0] code;
  logic [7:0]  pd;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdac_serial_ctrl #(.SYNC_STAGES(SYNC_ST)) dut_i (
    .clk(clk), .rst(rst), .por_mid_i(por_mid), .sclk_i(sclk),
    .sync_n_i(sync_n), .din_i(din), .sdo_o(sdo), .code_o(code),
    .pd_mode_o(pd), .ref_en_o(ref_en)
  );

  int    vectors = 0, fails = 0;
  string cur_req = "R4";
  bit    cmp_on = 1'b0;
  logic [15:0] m_code [4];
  logic [1:0]  m_pd   [4];
  bit m_ref = 1'b0, m_daisy = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    for (int i = 0; i < 4; i++) begin
      check(cur_req, "code", 64'(code[i*16 +: 16]), 64'(m_code[i]));
      check(cur_req, "pd", 64'(pd[i*2 +: 2]), 64'(m_pd[i]));
    end
    check(cur_req, "ref", 64'(ref_en), 64'(m_ref));
  end

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_code[i] = por_mid ? 16'h8000 : 16'h0000;
      m_pd[i] = 2'b00;
    end
    m_ref = 1'b0;
    m_daisy = 1'b0;
  endtask

  task automatic model_apply(input bit q[$]);
    logic [31:0] w;
    bit sel;
    if (q.size() < 32) return;
    for (int k = 0; k < 32; k++) w[31-k] = q[q.size()-32+k];
    case (w[27:24])
      4'b0000, 4'b0001, 4'b0010, 4'b0011:
        for (int i = 0; i < 4; i++)
          if (int'(w[23:20]) == i || w[23:20] == 4'hF) m_code[i] = w[19:4];
      4'b0100:
        for (int i = 0; i < 4; i++) begin
          sel = (i == 0) ? w[0] : (i == 1) ? w[1] : (i == 2) ? w[6] : w[7];
          if (m_ref || sel) m_pd[i] = w[19:18];
        end
      4'b0111:
        for (int i = 0; i < 4; i++) m_code[i] = por_mid ? 16'h8000 : 16'h0000;
      4'b1000: begin
        m_daisy = w[1];
        m_ref = w[0];
      end
      default: ;
    endcase
  endtask

  task automatic send_bits(input bit q[$]);
    bit ed;
    @(negedge clk);
    sync_n = 1'b0;
    repeat (HALF) @(negedge clk);
    foreach (q[k]) begin
      ed = (m_daisy && k >= 32) ? q[k-32] : 1'b0;
      check(m_daisy ? "R10" : "R9", "sdo", 64'(sdo), 64'(ed));
      din = q[k];
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    sync_n = 1'b1;
    repeat (SYNC_ST + 2) @(posedge clk);
    model_apply(q);
    repeat (HALF) @(negedge clk);
  endtask

  function automatic void push_word(ref bit q[$], input logic [31:0] w, input int n);
    for (int k = 31; k > 31 - n; k--) q.push_back(w[k]);
  endfunction

  task automatic send_word(input logic [31:0] w);
    bit q[$];
    push_word(q, w, 32);
    send_bits(q);
  endtask

  function automatic logic [31:0] wr_word(input logic [3:0] op, input logic [3:0] a,
                                          input logic [15:0] c);
    return {4'hA, op, a, c, 4'h5};
  endfunction

  function automatic logic [31:0] pd_word(input logic [1:0] m, input logic [3:0] sel);
    logic [31:0] w = {4'h0, 4'b0100, 4'h0, m, 18'h0};
    w[0] = sel[0]; w[1] = sel[1]; w[6] = sel[2]; w[7] = sel[3];
    return w;
  endfunction

  task automatic do_reset(input bit mid);
    cmp_on = 1'b0;
    @(negedge clk);
    por_mid = mid;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    model_reset();
    cur_req = "R4";
    check("R4", "reset code A", 64'(code[15:0]), mid ? 64'h8000 : 64'h0);
    check("R4", "reset pd", 64'(pd), 64'h0);
    check("R4", "reset sdo", 64'(sdo), 64'h0);
    cmp_on = 1'b1;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    bit q[$];
    do_reset(1'b0);

    cur_req = "R2";
    send_word(wr_word(4'b0011, 4'h0, 16'h1234));
    check("R2", "code A bit order", 64'(code[15:0]), 64'h1234);

    cur_req = "R3";
    send_word(wr_word(4'b0000, 4'h3, 16'hBEEF));
    check("R3", "code D", 64'(code[63:48]), 64'hBEEF);
    send_word(wr_word(4'b0010, 4'hF, 16'h5A5A));
    check("R3", "all codes", code, {4{16'h5A5A}});
    send_word(wr_word(4'b0001, 4'h2, 16'h0F0F));
    check("R3", "code C", 64'(code[47:32]), 64'h0F0F);

    cur_req = "R11";
    send_word(wr_word(4'b0011, 4'h5, 16'hFFFF));
    send_word(wr_word(4'b0101, 4'hF, 16'hFFFF));
    send_word(wr_word(4'b1111, 4'hF, 16'hFFFF) | 32'h3);
    check("R11", "codes unchanged", code, {16'h5A5A, 16'h0F0F, 16'h5A5A, 16'h5A5A});
    check("R11", "ref unchanged", 64'(ref_en), 64'h0);

    cur_req = "R1";
    q.delete(); push_word(q, wr_word(4'b0011, 4'h1, 16'h7777), 20); send_bits(q);
    q.delete(); push_word(q, wr_word(4'b0011, 4'h1, 16'h7777), 31); send_bits(q);
    check("R1", "short frames dropped", 64'(code[31:16]), 64'h5A5A);

    cur_req = "R9";
    q.delete(); push_word(q, 32'hFFFF_FFFF, 8);
    push_word(q, wr_word(4'b0011, 4'h1, 16'hC3C3), 32); send_bits(q);
    check("R9", "long frame last 32 bits", 64'(code[31:16]), 64'hC3C3);

    cur_req = "R7";
    send_word(pd_word(2'b01, 4'b0101));
    check("R7", "pd A,C", 64'(pd), 64'h11);
    send_word(pd_word(2'b11, 4'b1010));
    check("R7", "pd B,D", 64'(pd), 64'hDD);
    check("R7", "codes kept", 64'(code[31:16]), 64'hC3C3);

    cur_req = "R6";
    send_word(32'h0800_0001);
    check("R6", "ref on", 64'(ref_en), 64'h1);
    cur_req = "R8";
    send_word(pd_word(2'b10, 4'b0001));
    check("R8", "pd all", 64'(pd), 64'hAA);
    cur_req = "R6";
    send_word(32'h0800_0000);
    check("R6", "ref off", 64'(ref_en), 64'h0);
    cur_req = "R7";
    send_word(pd_word(2'b00, 4'b0010));
    check("R7", "pd B normal", 64'(pd), 64'hA2);

    cur_req = "R5";
    @(negedge clk); por_mid = 1'b1;
    send_word(32'h0700_0000);
    check("R5", "soft reset codes", code, {4{16'h8000}});
    check("R5", "soft reset keeps pd", 64'(pd), 64'hA2);

    cur_req = "R10";
    send_word(32'h0800_0002);
    q.delete(); push_word(q, 32'hDEAD_BEEF, 32);
    push_word(q, wr_word(4'b0011, 4'h2, 16'h4321), 32); send_bits(q);
    check("R10", "chain latch last word", 64'(code[47:32]), 64'h4321);
    send_word(32'h0800_0000);
    check("R10", "sdo quiet after", 64'(sdo), 64'h0);

    do_reset(1'b1);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule